// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port in which data moves in step with a shift clock. A host fills a one-word transmit buffer. When the shift register is free, the word moves into it and is shifted out on the data output. Meanwhile the receiver collects bits from the data input into a one-word receive buffer. Because the transmit path holds one word in the buffer and one in the shift register, the host can queue the next word while the current one is still going out.

The host controls the block through plain configuration inputs. A two-bit mode field either holds the whole unit in reset or runs it. Other inputs select the shift clock source, the frame length (8 or 16 bits), the bit order, inversion of each data line, enables for transmit and receive, and when the transmit interrupt fires. With the internal clock source the block makes a divided shift clock and drives it out. With the external source it follows a clock pin, which is synchronised into the system clock domain. Output data changes on the falling edge of the shift clock. Input data is sampled on the rising edge.

Status outputs report whether the shift register is empty, whether the transmit buffer is empty, whether a received word is waiting, and whether a received word was lost. Single-cycle interrupt pulses mark transmit and receive events.

Top module: `sync_serial_port`

## Requirements
- R1: While `cfg_mode` is not 2'b01 (2'b00 is the reset value; 2'b10 and 2'b11 are reserved and act the same), all unit state is cleared on the next clock: the shift register and transmit buffer read empty, `stat_rx_full` and `stat_overrun` are 0, `sclk_out` is high, and `tx_wr` is ignored.
- R2: With `cfg_clk_ext`=0 the block drives `sclk_oe`=1 and produces a shift clock whose high and low phases each last HALF_DIV system clocks, and which rests high while no frame is shifting. With `cfg_clk_ext`=1, `sclk_oe`=0 and shifting follows the edges of `sclk_in`.
- R3: `cfg_len8`=1 selects 8-bit frames, and `rx_rdata[15:8]` then reads 0. `cfg_len8`=0 selects 16-bit frames.
- R4: `cfg_msb_first`=0 sends and receives bit 0 first. `cfg_msb_first`=1 sends and receives the frame's top bit first (bit 7 or bit 15).
- R5: `sd_out` changes only together with a falling edge of the shift clock. `sd_in` is sampled at each rising edge.
- R6: While `cfg_tx_en`=0 no new frame starts, even if the transmit buffer holds a word.
- R7: `stat_tx_buf_empty` falls on the clock after a `tx_wr` and rises when the word moves into the shift register. `stat_tx_shift_empty` is 0 from that move until the last bit's rising edge.
- R8: When a full frame is received, `stat_rx_full` rises together with a one-cycle `irq_rx` pulse. A one-cycle `rx_rd` clears `stat_rx_full` on the next clock.
- R9: `cfg_tx_inv`=1 inverts `sd_out`. `cfg_rx_inv`=1 inverts `sd_in` before it is sampled.
- R10: With `cfg_txirq_on_done`=0, `irq_tx` pulses when a word moves from the buffer into the shift register. With `cfg_txirq_on_done`=1, it pulses when the last bit has been shifted, together with `stat_tx_shift_empty` going to 1.
- R11: If a frame completes while `stat_rx_full` is still 1, the receive buffer takes the new word and `stat_overrun` goes to 1. The flag stays 1 until `cfg_mode` leaves 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 2'b01 runs the unit; any other value holds it in reset |
| cfg_clk_ext | input | 1 | 1 selects the external shift clock |
| cfg_len8 | input | 1 | 1 selects 8-bit frames, 0 selects 16-bit frames |
| cfg_msb_first | input | 1 | 1 shifts the top bit first |
| cfg_txirq_on_done | input | 1 | Transmit interrupt timing select |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_tx_inv | input | 1 | Invert the data output |
| cfg_rx_inv | input | 1 | Invert the data input |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_wdata | input | FRAME_W | Word to transmit |
| rx_rd | input | 1 | Read strobe that clears the receive-full flag |
| rx_rdata | output | FRAME_W | Receive buffer contents |
| stat_tx_shift_empty | output | 1 | Shift register is idle |
| stat_tx_buf_empty | output | 1 | Transmit buffer is empty |
| stat_rx_full | output | 1 | Receive buffer holds an unread word |
| stat_overrun | output | 1 | A received word was overwritten before it was read |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| sclk_in | input | 1 | External shift clock |
| sd_out | output | 1 | Serial data output |
| sd_in | input | 1 | Serial data input |

## Verification
A wrong bit counter or a wrong shift direction shows up as a misordered or truncated word in `rx_rdata` within one frame time, because the bench loops the output back to the input and also records the line level at every rising edge of the shift clock. A buffer flag stuck in the wrong state shows up in the status outputs within one or two system clocks of a write or a load, and it also stalls or falsely starts the shift clock, which the bench watches over a fixed window. Overrun and reset-mode faults appear as soon as a second unread frame lands, or on the first clock after the mode leaves 2'b01.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        SSP_MODE_RESET = 2'b00,
        SSP_MODE_SYNC  = 2'b01,
        SSP_MODE_RSV2  = 2'b10,
        SSP_MODE_RSV3  = 2'b11
    } ssp_mode_e;

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unit_on,
    input  logic use_ext,
    input  logic want_fall,
    input  logic sclk_in,
    output logic fall_ev,
    output logic rise_ev,
    output logic sclk_gen
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             sclk;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       sync;
    } gen_st_t;

    gen_st_t q, d;
    logic    half_done;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[1:0], sclk_in};
        half_done = (q.cnt == CNT_LAST);
        fall_ev   = 1'b0;
        rise_ev   = 1'b0;
        if (!unit_on) begin
            d.sclk = 1'b1;
            d.cnt  = '0;
        end else if (use_ext) begin
            d.sclk  = 1'b1;
            d.cnt   = '0;
            fall_ev = q.sync[2] & ~q.sync[1];
            rise_ev = ~q.sync[2] & q.sync[1];
        end else if (half_done) begin
            if (!q.sclk) begin
                rise_ev = 1'b1;
                d.sclk  = 1'b1;
                d.cnt   = '0;
            end else if (want_fall) begin
                fall_ev = 1'b1;
                d.sclk  = 1'b0;
                d.cnt   = '0;
            end
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk <= 1'b1;
            q.cnt  <= '0;
            q.sync <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign sclk_gen = q.sclk;

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
    parameter int FRAME_W = 16,
    parameter int SHORT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_on,
    input  logic               tx_en,
    input  logic               len8,
    input  logic               msb_first,
    input  logic               out_inv,
    input  logic               irq_on_done,
    input  logic               wr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               fall_ev,
    input  logic               rise_ev,
    output logic               sd_out,
    output logic               want_fall,
    output logic               shift_empty,
    output logic               buf_empty,
    output logic               irq_tx
);

    localparam int BIT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] buf_w;
        logic               buf_full;
        logic [FRAME_W-1:0] sh;
        logic               busy;
        logic [BIT_W-1:0]   nbit;
        logic               obit;
        logic               irq;
    } tx_st_t;

    tx_st_t q, d;
    logic   load;
    logic [BIT_W-1:0] frame_last;

    function automatic logic lead_bit(input logic [FRAME_W-1:0] v,
                                      input logic is8, input logic msb);
        if (!msb)     return v[0];
        else if (is8) return v[SHORT_W-1];
        else          return v[FRAME_W-1];
    endfunction

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        frame_last = len8 ? BIT_W'(SHORT_W - 1) : BIT_W'(FRAME_W - 1);
        load       = fall_ev & ~q.busy & q.buf_full & tx_en;
        if (load) begin
            d.sh       = q.buf_w;
            d.busy     = 1'b1;
            d.nbit     = '0;
            d.buf_full = 1'b0;
            d.obit     = lead_bit(q.buf_w, len8, msb_first);
            d.irq      = ~irq_on_done;
        end else if (fall_ev && q.busy) begin
            d.sh   = msb_first ? (q.sh << 1) : (q.sh >> 1);
            d.obit = lead_bit(d.sh, len8, msb_first);
        end
        if (rise_ev && q.busy) begin
            d.nbit = q.nbit + BIT_W'(1);
            if (q.nbit == frame_last) begin
                d.busy = 1'b0;
                d.irq  = irq_on_done;
            end
        end
        if (wr) begin
            d.buf_w    = wdata;
            d.buf_full = 1'b1;
        end
        if (!unit_on) begin
            d      = '0;
            d.obit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.obit <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sd_out      = q.obit ^ out_inv;
    assign want_fall   = q.busy | (q.buf_full & tx_en);
    assign shift_empty = ~q.busy;
    assign buf_empty   = ~q.buf_full;
    assign irq_tx      = q.irq;

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
    parameter int FRAME_W = 16,
    parameter int SHORT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_on,
    input  logic               rx_en,
    input  logic               len8,
    input  logic               msb_first,
    input  logic               in_inv,
    input  logic               sd_in,
    input  logic               rd,
    input  logic               rise_ev,
    output logic [FRAME_W-1:0] rdata,
    output logic               full,
    output logic               overrun,
    output logic               irq_rx
);

    localparam int BIT_W = $clog2(FRAME_W + 1);
    localparam logic [FRAME_W-1:0] LOW_MASK =
        {{(FRAME_W - SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    typedef struct packed {
        logic [1:0]         sync;
        logic [FRAME_W-1:0] sh;
        logic [BIT_W-1:0]   nbit;
        logic [FRAME_W-1:0] buf_w;
        logic               full;
        logic               ovr;
        logic               irq;
    } rx_st_t;

    rx_st_t q, d;
    logic   smp;
    logic   done;
    logic [FRAME_W-1:0] shifted;
    logic [BIT_W-1:0]   frame_last;

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        d.sync     = {q.sync[0], sd_in};
        smp        = q.sync[1] ^ in_inv;
        done       = 1'b0;
        frame_last = len8 ? BIT_W'(SHORT_W - 1) : BIT_W'(FRAME_W - 1);
        if (msb_first) begin
            shifted = {q.sh[FRAME_W-2:0], smp};
        end else begin
            shifted = q.sh >> 1;
            if (len8) shifted[SHORT_W-1] = smp;
            else      shifted[FRAME_W-1] = smp;
        end
        if (rx_en && rise_ev) begin
            if (q.nbit == frame_last) begin
                done    = 1'b1;
                d.buf_w = len8 ? (shifted & LOW_MASK) : shifted;
                d.full  = 1'b1;
                d.ovr   = q.ovr | (q.full & ~rd);
                d.irq   = 1'b1;
                d.sh    = '0;
                d.nbit  = '0;
            end else begin
                d.sh   = shifted;
                d.nbit = q.nbit + BIT_W'(1);
            end
        end
        if (!rx_en) begin
            d.sh   = '0;
            d.nbit = '0;
        end
        if (rd && !done) d.full = 1'b0;
        if (!unit_on) begin
            d      = '0;
            d.sync = {q.sync[0], sd_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata   = q.buf_w;
    assign full    = q.full;
    assign overrun = q.ovr;
    assign irq_rx  = q.irq;

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int SHORT_W  = 8,
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_clk_ext,
    input  logic               cfg_len8,
    input  logic               cfg_msb_first,
    input  logic               cfg_txirq_on_done,
    input  logic               cfg_tx_en,
    input  logic               cfg_rx_en,
    input  logic               cfg_tx_inv,
    input  logic               cfg_rx_inv,
    input  logic               tx_wr,
    input  logic [FRAME_W-1:0] tx_wdata,
    input  logic               rx_rd,
    output logic [FRAME_W-1:0] rx_rdata,
    output logic               stat_tx_shift_empty,
    output logic               stat_tx_buf_empty,
    output logic               stat_rx_full,
    output logic               stat_overrun,
    output logic               irq_tx,
    output logic               irq_rx,
    output logic               sclk_out,
    output logic               sclk_oe,
    input  logic               sclk_in,
    output logic               sd_out,
    input  logic               sd_in
);

    logic unit_on;
    logic fall_ev;
    logic rise_ev;
    logic want_fall;
    logic sclk_gen;

    assign unit_on = (cfg_mode == SSP_MODE_SYNC);

    ssp_clkgen #(.HALF_DIV(HALF_DIV)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_on   (unit_on),
        .use_ext   (cfg_clk_ext),
        .want_fall (want_fall),
        .sclk_in   (sclk_in),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .sclk_gen  (sclk_gen)
    );

    ssp_tx #(.FRAME_W(FRAME_W), .SHORT_W(SHORT_W)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .unit_on     (unit_on),
        .tx_en       (cfg_tx_en),
        .len8        (cfg_len8),
        .msb_first   (cfg_msb_first),
        .out_inv     (cfg_tx_inv),
        .irq_on_done (cfg_txirq_on_done),
        .wr          (tx_wr),
        .wdata       (tx_wdata),
        .fall_ev     (fall_ev),
        .rise_ev     (rise_ev),
        .sd_out      (sd_out),
        .want_fall   (want_fall),
        .shift_empty (stat_tx_shift_empty),
        .buf_empty   (stat_tx_buf_empty),
        .irq_tx      (irq_tx)
    );

    ssp_rx #(.FRAME_W(FRAME_W), .SHORT_W(SHORT_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_on   (unit_on),
        .rx_en     (cfg_rx_en),
        .len8      (cfg_len8),
        .msb_first (cfg_msb_first),
        .in_inv    (cfg_rx_inv),
        .sd_in     (sd_in),
        .rd        (rx_rd),
        .rise_ev   (rise_ev),
        .rdata     (rx_rdata),
        .full      (stat_rx_full),
        .overrun   (stat_overrun),
        .irq_rx    (irq_rx)
    );

    assign sclk_out = sclk_gen;
    assign sclk_oe  = unit_on & ~cfg_clk_ext;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_clk_ext,
    input logic       cfg_tx_en,
    input logic       cfg_txirq_on_done,
    input logic       cfg_tx_inv,
    input logic       tx_wr,
    input logic       stat_tx_shift_empty,
    input logic       stat_tx_buf_empty,
    input logic       stat_rx_full,
    input logic       stat_overrun,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       sclk_out,
    input logic       sclk_oe,
    input logic       sd_out
);

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'b01) |=> (stat_tx_shift_empty && stat_tx_buf_empty &&
                                 !stat_rx_full && !stat_overrun && sclk_out)); // R1

    AST_SCLK_RESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && stat_tx_shift_empty) |-> sclk_out); // R2

    AST_TX_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && $past(cfg_mode) == 2'b01 && !cfg_clk_ext &&
         !$past(cfg_clk_ext) && $stable(cfg_tx_inv) && !$stable(sd_out)) |-> !sclk_out); // R5

    AST_TX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && !cfg_tx_en && stat_tx_shift_empty) |=> stat_tx_shift_empty); // R6

    AST_WR_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && tx_wr) |=> !stat_tx_buf_empty); // R7

    AST_RX_FULL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rx_full) |-> irq_rx); // R8

    AST_TXIRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && $past(cfg_txirq_on_done)) |-> stat_tx_shift_empty); // R10

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b01 && stat_overrun) |=> stat_overrun); // R11

endmodule

bind sync_serial_port ssp_checker chk_i (.*);

// File: tb/sync_serial_port_tb_top.sv
`timescale 1ns/1ps
module sync_serial_port_tb_top;

    localparam int FRAME_W  = 16;
    localparam int SHORT_W  = 8;
    localparam int HALF_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        cfg_clk_ext = 0, cfg_len8 = 0, cfg_msb_first = 0, cfg_txirq_on_done = 0;
    logic        cfg_tx_en = 0, cfg_rx_en = 0, cfg_tx_inv = 0, cfg_rx_inv = 0;
    logic        tx_wr = 0, rx_rd = 0;
    logic [15:0] tx_wdata = '0;
    logic [15:0] rx_rdata;
    logic        stat_tx_shift_empty, stat_tx_buf_empty, stat_rx_full, stat_overrun;
    logic        irq_tx, irq_rx, sclk_out, sclk_oe, sd_out;
    logic        sclk_in = 1'b1;
    logic        sd_drv = 1'b0;
    logic        loop_en = 1'b1;
    logic        sd_in_w;

    int n_tests = 0;
    int n_fail  = 0;

    int          mon_cnt = 0;
    logic [15:0] mon_word = '0;
    realtime     tr0, tr1;

    always #2.5 clk = ~clk;

    assign sd_in_w = loop_en ? sd_out : sd_drv;

    sync_serial_port #(.FRAME_W(FRAME_W), .SHORT_W(SHORT_W), .HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_ext(cfg_clk_ext),
        .cfg_len8(cfg_len8), .cfg_msb_first(cfg_msb_first),
        .cfg_txirq_on_done(cfg_txirq_on_done), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_tx_inv(cfg_tx_inv), .cfg_rx_inv(cfg_rx_inv), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .stat_tx_shift_empty(stat_tx_shift_empty),
        .stat_tx_buf_empty(stat_tx_buf_empty), .stat_rx_full(stat_rx_full),
        .stat_overrun(stat_overrun), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in),
        .sd_out(sd_out), .sd_in(sd_in_w)
    );

    // line monitor: level of sd_out at each rising edge of the generated clock
    always @(posedge sclk_out) begin
        if (sclk_oe) begin
            if (mon_cnt == 0) tr0 = $realtime;
            if (mon_cnt == 1) tr1 = $realtime;
            if (mon_cnt < 16) mon_word[mon_cnt] = sd_out;
            mon_cnt = mon_cnt + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] line_bits(input logic [15:0] data, input bit is8,
                                              input bit msb, input bit inv);
        int n = is8 ? 8 : 16;
        logic [15:0] e = '0;
        for (int i = 0; i < n; i++) e[i] = (msb ? data[n-1-i] : data[i]) ^ inv;
        return e;
    endfunction

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        @(negedge clk);
    endtask

    task automatic write_tx(input logic [15:0] v);
        mon_cnt  = 0;
        mon_word = '0;
        @(negedge clk);
        tx_wr    = 1'b1;
        tx_wdata = v;
        @(negedge clk);
        tx_wr    = 1'b0;
    endtask

    task automatic wait_rx(input string req);
        int k = 0;
        while (!stat_rx_full && k < 2000) begin
            @(negedge clk);
            k++;
        end
        check(req, "frame received in time", 32'(stat_rx_full), 32'd1);
    endtask

    task automatic read_rx(output logic [15:0] v);
        v = rx_rdata;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic cfg_run(input bit is8, input bit msb, input bit oinv, input bit iinv);
        set_mode(2'b00);
        cfg_clk_ext = 0; cfg_len8 = is8; cfg_msb_first = msb;
        cfg_tx_inv = oinv; cfg_rx_inv = iinv; cfg_tx_en = 1; cfg_rx_en = 1;
        cfg_txirq_on_done = 0; loop_en = 1;
        set_mode(2'b01);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        check("R1", "shift empty after reset", 32'(stat_tx_shift_empty), 32'd1);
        check("R1", "buffer empty after reset", 32'(stat_tx_buf_empty), 32'd1);
        check("R1", "rx full after reset", 32'(stat_rx_full), 32'd0);
        check("R1", "overrun after reset", 32'(stat_overrun), 32'd0);
        check("R1", "sclk idle high", 32'(sclk_out), 32'd1);
        cfg_tx_en = 1; cfg_rx_en = 1;
        write_tx(16'h1111);
        check("R1", "write ignored in mode 00", 32'(stat_tx_buf_empty), 32'd1);
        cfg_mode = 2'b11;
        write_tx(16'h2222);
        check("R1", "write ignored in reserved mode", 32'(stat_tx_buf_empty), 32'd1);
        set_mode(2'b01);
        begin
            bit low_seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!sclk_out) low_seen = 1;
            end
            check("R1", "no frame from ignored writes", 32'(low_seen), 32'd0);
        end
        check("R2", "clock driven when internal", 32'(sclk_oe), 32'd1);
    endtask

    task automatic t_lsb16;
        logic [15:0] v;
        cfg_run(0, 0, 0, 0);
        write_tx(16'hA5C3);
        check("R7", "buffer full after write", 32'(stat_tx_buf_empty), 32'd0);
        @(negedge clk);
        check("R7", "buffer empty after load", 32'(stat_tx_buf_empty), 32'd1);
        check("R7", "shift busy after load", 32'(stat_tx_shift_empty), 32'd0);
        wait_rx("R8");
        check("R8", "rx full set", 32'(stat_rx_full), 32'd1);
        check("R3", "16-bit loopback word", 32'(rx_rdata), 32'hA5C3);
        check("R4", "lsb-first line order", 32'(mon_word), 32'(line_bits(16'hA5C3, 0, 0, 0)));
        check("R2", "shift clock period ns", 32'(int'(tr1 - tr0)), 32'(2 * HALF_DIV * 5));
        check("R7", "shift empty at end", 32'(stat_tx_shift_empty), 32'd1);
        read_rx(v);
        check("R8", "rx full cleared by read", 32'(stat_rx_full), 32'd0);
    endtask

    task automatic t_msb8;
        logic [15:0] v;
        cfg_run(1, 1, 0, 0);
        write_tx(16'hFF5A);
        wait_rx("R3");
        check("R3", "8-bit word, upper byte zero", 32'(rx_rdata), 32'h005A);
        check("R4", "msb-first line order", 32'(mon_word), 32'(line_bits(16'h005A, 1, 1, 0)));
        check("R3", "exactly 8 clocks", 32'(mon_cnt), 32'd8);
        read_rx(v);
    endtask

    task automatic t_polarity;
        logic [15:0] v;
        cfg_run(0, 0, 1, 0);
        write_tx(16'h3C81);
        wait_rx("R9");
        check("R9", "output inverted on line", 32'(mon_word), 32'(line_bits(16'h3C81, 0, 0, 1)));
        check("R9", "received inverted word", 32'(rx_rdata), 32'hC37E);
        read_rx(v);
        cfg_run(1, 0, 1, 1);
        write_tx(16'h00B4);
        wait_rx("R9");
        check("R9", "double inversion restores", 32'(rx_rdata), 32'h00B4);
        read_rx(v);
    endtask

    task automatic t_tx_gate;
        logic [15:0] v;
        bit low_seen = 0;
        cfg_run(0, 1, 0, 0);
        cfg_tx_en = 0;
        write_tx(16'h1234);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!sclk_out) low_seen = 1;
        end
        check("R6", "no clock while disabled", 32'(low_seen), 32'd0);
        check("R6", "shift stays empty", 32'(stat_tx_shift_empty), 32'd1);
        check("R6", "buffer keeps word", 32'(stat_tx_buf_empty), 32'd0);
        cfg_tx_en = 1;
        wait_rx("R6");
        check("R6", "word sent after enable", 32'(rx_rdata), 32'h1234);
        read_rx(v);
    endtask

    task automatic t_irq_sel;
        logic [15:0] v;
        int k;
        cfg_run(1, 0, 0, 0);
        write_tx(16'h0077);
        k = 0;
        while (!irq_tx && k < 100) begin @(negedge clk); k++; end
        check("R10", "irq on load seen", 32'(irq_tx), 32'd1);
        check("R10", "busy at load irq", 32'(stat_tx_shift_empty), 32'd0);
        wait_rx("R10");
        read_rx(v);
        cfg_txirq_on_done = 1;
        write_tx(16'h0066);
        k = 0;
        while (!irq_tx && k < 500) begin @(negedge clk); k++; end
        check("R10", "irq on done seen", 32'(irq_tx), 32'd1);
        check("R10", "shift empty at done irq", 32'(stat_tx_shift_empty), 32'd1);
        check("R10", "all bits sent at done irq", 32'(mon_cnt), 32'd8);
        wait_rx("R10");
        read_rx(v);
    endtask

    task automatic t_overrun;
        cfg_run(1, 1, 0, 0);
        write_tx(16'h0011);
        wait_rx("R11");
        check("R11", "no overrun after one frame", 32'(stat_overrun), 32'd0);
        write_tx(16'h0022);
        repeat (200) @(negedge clk);
        check("R11", "overrun set", 32'(stat_overrun), 32'd1);
        check("R11", "buffer overwritten", 32'(rx_rdata), 32'h0022);
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
        repeat (5) @(negedge clk);
        check("R11", "overrun survives read", 32'(stat_overrun), 32'd1);
        set_mode(2'b00);
        check("R1", "overrun cleared in reset mode", 32'(stat_overrun), 32'd0);
        set_mode(2'b01);
        check("R11", "overrun stays clear", 32'(stat_overrun), 32'd0);
    endtask

    task automatic t_ext_clock;
        logic [15:0] cap = '0;
        logic [15:0] v;
        logic [7:0]  rxd = 8'h96;
        set_mode(2'b00);
        cfg_clk_ext = 1; cfg_len8 = 1; cfg_msb_first = 0; cfg_tx_inv = 0; cfg_rx_inv = 0;
        cfg_tx_en = 1; cfg_rx_en = 1; cfg_txirq_on_done = 0; loop_en = 0; sclk_in = 1;
        set_mode(2'b01);
        check("R2", "clock not driven when external", 32'(sclk_oe), 32'd0);
        write_tx(16'h003C);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 0;
            sd_drv  = rxd[i];
            repeat (8) @(negedge clk);
            cap[i]  = sd_out;
            sclk_in = 1;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check("R5", "ext clock rx sampled on rise", 32'(rx_rdata), 32'h0096);
        check("R5", "ext clock tx changed on fall", 32'(cap), 32'h003C);
        check("R2", "ext frame ended", 32'(stat_tx_shift_empty), 32'd1);
        read_rx(v);
        loop_en = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_lsb16();
        t_msb8();
        t_polarity();
        t_tx_gate();
        t_irq_sel();
        t_overrun();
        t_ext_clock();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule